// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Adder

This block adds two unsigned operands and a carry-in. It returns their sum and the carry-out. Every carry is formed by a sparse binary-tree prefix network built from generate/propagate merge cells. A forward pass of the tree merges neighbouring spans of 2, 4, 8 and more bits. A reverse pass then fills in the carries that the forward pass left out. The depth of the carry logic therefore grows with the logarithm of the width. The number of merge cells stays close to twice the width.

The carry-in is treated as the generate term of an imaginary position just below bit 0. A single final merge per bit folds it into each group term. Each sum bit is the bit's own propagate term XORed with the carry into that bit, which adds a constant depth after the carries.

The result is captured in one output register. It appears one clock edge after the operands are presented. The operand width is a parameter and must be a power of two of at least 2.

Top module: `bk_adder`

## Requirements
- R1: While rst_n is low, sum and carry_out are both zero.
- R2: At each rising clock edge with rst_n high, {carry_out, sum} takes the value op_a + op_b + carry_in, using the inputs present at that edge. The value is readable until the next edge.
- R3: When every bit position propagates (op_b equals the bitwise inverse of op_a), carry_out equals carry_in. The sum is all ones for carry_in 0 and all zeros for carry_in 1.
- R4: With both operands zero and carry_in 1, the sum is 1 and carry_out is 0. With both operands all ones and carry_in 1, the sum is all ones and carry_out is 1.
- R5: When both most significant operand bits are 1, carry_out is 1, whatever the other bits and the carry-in are.
- R6: A carry generated at any single bit position i (op_a = op_b = 1 shifted left by i, carry_in 0) arrives at bit i+1. For i = WIDTH-1 it arrives at carry_out. This exercises every carry node of both passes of the tree.
- R7: With WIDTH set to 4, all 512 combinations of operands and carry-in give the correct sum and carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; result captured on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| carry_out | output | 1 | Registered carry out of the top bit |

## Verification
Each carry node in the tree feeds exactly one sum bit, or carry_out for the top node. A wrong merge cell or a wrong span shows up as a flipped sum bit one edge after the operands that activate that node. The single-position generate sweep activates each node alone, so a fault is tied to one bit position. The all-propagate patterns stretch a carry across the full width. The exhaustive 4-bit sweep covers every input of the small tree, and random 16-bit vectors cover the deeper levels.

// File: rtl/bk_pkg.sv
package bk_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a more-significant span (hi) with the adjacent less-significant span (lo)
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/bk_gp_cell.sv
module bk_gp_cell
    import bk_pkg::*;
(
    input  logic hi_g,
    input  logic hi_p,
    input  logic lo_g,
    input  logic lo_p,
    output logic g,
    output logic p
);
    gp_t merged;

    always_comb begin
        merged = gp_merge('{g: hi_g, p: hi_p}, '{g: lo_g, p: lo_p});
        g      = merged.g;
        p      = merged.p;
    end
endmodule

// File: rtl/bk_bit_terms.sv
module bk_bit_terms #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] bit_g,
    output logic [WIDTH-1:0] bit_p
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_g[i] = op_a[i] & op_b[i];
        assign bit_p[i] = op_a[i] ^ op_b[i];
    end
endmodule

// File: rtl/bk_prefix_tree.sv
module bk_prefix_tree #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] bit_g,
    input  logic [WIDTH-1:0] bit_p,
    output logic [WIDTH-1:0] grp_g,   // generate over bits i..0
    output logic [WIDTH-1:0] grp_p    // propagate over bits i..0
);
    localparam int LOG2  = $clog2(WIDTH);
    localparam int N_FWD = LOG2;
    localparam int N_REV = LOG2 - 1;
    localparam int N_STG = N_FWD + N_REV;

    logic [WIDTH-1:0] stg_g [0:N_STG];
    logic [WIDTH-1:0] stg_p [0:N_STG];

    assign stg_g[0] = bit_g;
    assign stg_p[0] = bit_p;

    for (genvar s = 0; s < N_STG; s++) begin : g_stage
        // Forward stages climb spans 1,2,4..; reverse stages descend them again
        localparam int  LVL  = (s < N_FWD) ? s : (2 * LOG2 - 2 - s);
        localparam int  SPAN = 1 << LVL;
        localparam bit  FWD  = (s < N_FWD);
        for (genvar i = 0; i < WIDTH; i++) begin : g_col
            localparam bit ACTIVE = FWD
                ? (((i + 1) % (2 * SPAN)) == 0)
                : ((i >= 3 * SPAN - 1) && (((i + 1 - SPAN) % (2 * SPAN)) == 0));
            if (ACTIVE) begin : g_cell
                bk_gp_cell u_cell (
                    .hi_g (stg_g[s][i]),
                    .hi_p (stg_p[s][i]),
                    .lo_g (stg_g[s][i-SPAN]),
                    .lo_p (stg_p[s][i-SPAN]),
                    .g    (stg_g[s+1][i]),
                    .p    (stg_p[s+1][i])
                );
            end else begin : g_pass
                assign stg_g[s+1][i] = stg_g[s][i];
                assign stg_p[s+1][i] = stg_p[s][i];
            end
        end
    end

    assign grp_g = stg_g[N_STG];
    assign grp_p = stg_p[N_STG];
endmodule

// File: rtl/bk_sum_stage.sv
module bk_sum_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] bit_p,
    input  logic [WIDTH-1:0] grp_g,
    input  logic [WIDTH-1:0] grp_p,
    input  logic             carry_in,
    output logic [WIDTH:0]   carries,
    output logic [WIDTH-1:0] sum_raw
);
    assign carries[0] = carry_in;

    // Fold the carry-in as the generate of a virtual position below bit 0
    for (genvar i = 0; i < WIDTH; i++) begin : g_fold
        logic unused_p;
        bk_gp_cell u_fold (
            .hi_g (grp_g[i]),
            .hi_p (grp_p[i]),
            .lo_g (carry_in),
            .lo_p (1'b0),
            .g    (carries[i+1]),
            .p    (unused_p)
        );
    end

    assign sum_raw = bit_p ^ carries[WIDTH-1:0];
endmodule

// File: rtl/bk_adder.sv
module bk_adder #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int W1 = WIDTH + 1;

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } result_t;

    logic [WIDTH-1:0] bit_g, bit_p, grp_g, grp_p, sum_raw;
    logic [WIDTH:0]   carries;
    result_t          res_d, res_q;
    logic             seen_d, seen_q;

    bk_bit_terms #(.WIDTH(WIDTH)) u_terms (
        .op_a (op_a),
        .op_b (op_b),
        .bit_g(bit_g),
        .bit_p(bit_p)
    );

    bk_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .bit_g(bit_g),
        .bit_p(bit_p),
        .grp_g(grp_g),
        .grp_p(grp_p)
    );

    bk_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .bit_p   (bit_p),
        .grp_g   (grp_g),
        .grp_p   (grp_p),
        .carry_in(carry_in),
        .carries (carries),
        .sum_raw (sum_raw)
    );

    always_comb begin
        res_d.sum  = sum_raw;
        res_d.cout = carries[WIDTH];
        seen_d     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            res_q  <= res_d;
            seen_q <= seen_d;
        end
    end

    assign sum       = res_q.sum;
    assign carry_out = res_q.cout;

    // R2: registered result equals arithmetic sum of the previous edge's inputs
    p_sum_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ({carry_out, sum} ==
                    (W1'({1'b0, $past(op_a)}) + W1'({1'b0, $past(op_b)}) + W1'($past(carry_in)))));

    // R3: full propagate passes the carry-in straight through
    p_full_prop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&(op_a ^ op_b)) |-> (carries[WIDTH] == carry_in));

    // R5: generate in the top position forces the carry-out
    p_top_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a[WIDTH-1] & op_b[WIDTH-1]) |-> carries[WIDTH]);

    // R4: zero operands leave only the carry-in at bit 0
    p_cin_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_a == '0) && (op_b == '0)) |-> (sum_raw == WIDTH'(carry_in) && !carries[WIDTH]));

    // R6: the tree's group propagate over bits i..0 is the AND of the bit propagates
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        p_grp_prop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            grp_p[i] == (&bit_p[i:0]));
    end
endmodule

// File: tb/bk_adder_tb_top.sv
`timescale 1ns/1ps
module bk_adder_tb_top;
    localparam int W  = 16;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0]  a16, b16, s16;
    logic          ci16, co16;
    logic [WS-1:0] a4, b4, s4;
    logic          ci4, co4;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bk_adder #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16),
        .carry_in(ci16), .sum(s16), .carry_out(co16)
    );

    bk_adder #(.WIDTH(WS)) dut4_i (
        .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4),
        .carry_in(ci4), .sum(s4), .carry_out(co4)
    );

    task automatic check16(string req, logic [W:0] act, logic [W:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run16(string req, logic [W-1:0] a, logic [W-1:0] b, logic ci);
        logic [W:0] exp;
        a16 = a; b16 = b; ci16 = ci;
        exp = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
        @(negedge clk);
        check16(req, {co16, s16}, exp);
    endtask

    task automatic run4(logic [WS-1:0] a, logic [WS-1:0] b, logic ci);
        logic [WS:0] exp;
        a4 = a; b4 = b; ci4 = ci;
        exp = {1'b0, a} + {1'b0, b} + (WS+1)'(ci);
        @(negedge clk);
        n_cmp++;
        if ({co4, s4} !== exp) begin
            n_bad++;
            $display("FAIL R7: a=%h b=%h ci=%b actual %h expected %h", a, b, ci, {co4, s4}, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        a16 = 16'hFFFF; b16 = 16'hFFFF; ci16 = 1'b1;
        a4 = 4'hF; b4 = 4'hF; ci4 = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero despite active inputs
        check16("R1", {co16, s16}, '0);
        n_cmp++;
        if ({co4, s4} !== 5'd0) begin
            n_bad++;
            $display("FAIL R1: actual %h expected 0", {co4, s4});
        end
        rst_n = 1'b1;

        // R4: carry-in alone, and all-ones with carry-in
        run16("R4", 16'h0000, 16'h0000, 1'b1);
        run16("R4", 16'hFFFF, 16'hFFFF, 1'b1);
        run16("R2", 16'h0000, 16'h0000, 1'b0);

        // R3: all positions propagate
        run16("R3", 16'hA5C3, 16'h5A3C, 1'b0);
        run16("R3", 16'hA5C3, 16'h5A3C, 1'b1);
        run16("R3", 16'h0000, 16'hFFFF, 1'b1);
        run16("R3", 16'h0000, 16'hFFFF, 1'b0);

        // R5: top-bit generate
        run16("R5", 16'h8000, 16'h8000, 1'b0);
        run16("R5", 16'h8001, 16'hC000, 1'b1);

        // R6: single-position generate reaches the next bit
        for (int i = 0; i < W; i++) begin
            run16("R6", W'(1) << i, W'(1) << i, 1'b0);
        end
        // R6: generate at bit i ripples through a propagate run above it
        for (int i = 0; i < W; i++) begin
            logic [W-1:0] run_mask;
            run_mask = ~((W'(1) << (i + 1)) - W'(1));
            run16("R6", (W'(1) << i) | run_mask, W'(1) << i, 1'b0);
        end

        // R7: exhaustive small configuration
        for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    run4(WS'(a), WS'(b), ci[0]);
                end
            end
        end

        // R2: random full-width vectors
        for (int k = 0; k < 3000; k++) begin
            run16("R2", W'($urandom), W'($urandom), 1'($urandom));
        end

        // R1: reset re-asserted mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check16("R1", {co16, s16}, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule